// File: doc/BRIEF.md
# Subtree Index Pipeline Dispatcher

This block sits in front of a bank of parallel, equal-depth tree-walk pipelines. Each pipeline holds a disjoint set of subtrees of a packet-classification decision tree. For every incoming header key the block finds the pipeline that owns the covering subtree, along with the root node address of that subtree. It then issues the key to that one pipeline. All other pipelines see no valid for that packet, so only one memory chain is active per classification.

The index has two parts. A direct-mapped table is addressed by the top cutting bits of the key and covers subtrees rooted at the first tree level. A small ternary table covers subtrees that were split out deeper in the tree. A ternary hit overrides the direct table.

On the return side, the block merges the single valid result from the pipelines into one output stream. Because every pipeline has the same depth, results leave in the order the keys arrived, and no reorder storage is needed. If more than one pipeline presents a result in the same cycle, an error flag is raised.

Top module: `subtree_dispatch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `disp_vld`, `out_vld` and `out_err` are all 0.
- R2: One cycle after `in_valid` is high, exactly one bit of `disp_vld` is set. One cycle after `in_valid` is low, `disp_vld` is all zero.
- R3: The direct table is indexed by the top CUT_W bits of `in_key`. Entry i sits at `dir_cfg[i*ENT_W +: ENT_W]` and is packed as {pipeline ID in the upper PID_W bits, node address in the lower NODE_W bits}. With no ternary hit, `disp_vld` sets bit pipeline ID and `disp_node` equals that entry's node address.
- R4: Ternary entry j hits when `tcam_en[j]` is 1 and `(in_key & msk_j) == (val_j & msk_j)`. A mask bit of 1 means the bit is compared. The value and mask of entry j are slice j of `tcam_val` and `tcam_msk`. An entry whose `tcam_en` bit is 0 never hits.
- R5: When any ternary entry hits, its `tcam_res` entry, packed like a direct entry, sets the pipeline and node address instead of the direct table.
- R6: When several ternary entries hit, the lowest entry index wins.
- R7: `disp_key` equals the `in_key` presented one cycle earlier whenever `disp_vld` is non-zero.
- R8: One cycle after any `res_vld` bit is high, `out_vld` is 1 and `out_data` equals the `res_data` slice of the lowest-indexed valid pipeline. With no valid input, `out_vld` is 0.
- R9: `out_err` is 1 exactly one cycle after a cycle in which more than one `res_vld` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header key valid |
| in_key | input | KEY_W | Header key bits used for indexing |
| dir_cfg | input | DIR_N*ENT_W | Direct table contents, {pid,node} per entry |
| tcam_val | input | T_N*KEY_W | Ternary compare values |
| tcam_msk | input | T_N*KEY_W | Ternary care masks (1 = compare) |
| tcam_en | input | T_N | Ternary entry enables |
| tcam_res | input | T_N*ENT_W | Ternary results, {pid,node} per entry |
| disp_vld | output | P | One-hot issue strobe per pipeline |
| disp_key | output | KEY_W | Key issued to the pipelines |
| disp_node | output | NODE_W | Subtree root node address |
| res_vld | input | P | Result valid from each pipeline |
| res_data | input | P*RES_W | Result from each pipeline |
| out_vld | output | 1 | Merged result valid |
| out_data | output | RES_W | Merged result |
| out_err | output | 1 | More than one pipeline result in one cycle |

## Verification
The hardest case to reach is a key that matches several ternary entries at once and also has a live direct-table entry, because random keys almost never satisfy a masked compare. The stimulus therefore builds half of its keys from a chosen ternary entry's value, flipping only don't-care bits. Some entries are set up with overlapping value and mask pairs, so multi-hit priority and override are exercised often. A directed key also hits a disabled entry, to show that the disabled entry is ignored.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int unsigned SDX_PIPES   = 8;
  localparam int unsigned SDX_KEY_W   = 16;
  localparam int unsigned SDX_CUT_W   = 4;
  localparam int unsigned SDX_TERN_N  = 4;
  localparam int unsigned SDX_NODE_W  = 8;
  localparam int unsigned SDX_RES_W   = 8;
endpackage

// File: rtl/sdx_tern_match.sv
module sdx_tern_match #(
  parameter int unsigned KEY_W = 16,
  parameter int unsigned T_N   = 4,
  parameter int unsigned ENT_W = 11
) (
  input  logic [KEY_W-1:0]     key,
  input  logic [T_N*KEY_W-1:0] val,
  input  logic [T_N*KEY_W-1:0] msk,
  input  logic [T_N-1:0]       en,
  input  logic [T_N*ENT_W-1:0] res,
  output logic                 hit,
  output logic [ENT_W-1:0]     ent
);
  logic [T_N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < T_N; g++) begin : g_cmp
      assign match[g] = en[g] &&
        ((key & msk[g*KEY_W +: KEY_W]) == (val[g*KEY_W +: KEY_W] & msk[g*KEY_W +: KEY_W]));
    end
  endgenerate

  // Priority: scan from the top so the lowest index is written last.
  always_comb begin
    ent = '0;
    for (int i = T_N - 1; i >= 0; i--) begin
      if (match[i]) ent = res[i*ENT_W +: ENT_W];
    end
    hit = |match;
  end
endmodule

// File: rtl/sdx_issue.sv
module sdx_issue #(
  parameter int unsigned P      = 8,
  parameter int unsigned KEY_W  = 16,
  parameter int unsigned NODE_W = 8,
  localparam int unsigned PID_W = (P > 1) ? $clog2(P) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [PID_W-1:0]  pid,
  input  logic [NODE_W-1:0] node,
  output logic [P-1:0]      vld_q,
  output logic [KEY_W-1:0]  key_q,
  output logic [NODE_W-1:0] node_q
);
  logic [P-1:0] vld_d;

  always_comb begin
    vld_d = '0;
    if (in_valid) vld_d[pid] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      node_q <= '0;
    end else if (in_valid) begin
      key_q  <= in_key;
      node_q <= node;
    end
  end

  // R2
  disp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_q));
  // R2
  disp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|vld_q) == $past(in_valid));
  // R7
  disp_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (key_q == $past(in_key)));
endmodule

// File: rtl/sdx_merge.sv
module sdx_merge #(
  parameter int unsigned P     = 8,
  parameter int unsigned RES_W = 8,
  localparam int unsigned CNT_W = $clog2(P + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [P-1:0]     res_vld,
  input  logic [P*RES_W-1:0] res_data,
  output logic             out_vld,
  output logic [RES_W-1:0] out_data,
  output logic             out_err
);
  logic [RES_W-1:0] sel_d;
  logic [CNT_W-1:0] cnt_d;
  logic             any_d;

  always_comb begin
    sel_d = '0;
    cnt_d = '0;
    for (int i = P - 1; i >= 0; i--) begin
      if (res_vld[i]) begin
        sel_d = res_data[i*RES_W +: RES_W];
        cnt_d = cnt_d + 1'b1;
      end
    end
    any_d = |res_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_err <= 1'b0;
    end else begin
      out_vld <= any_d;
      out_err <= (cnt_d > 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_data <= '0;
    else if (any_d) out_data <= sel_d;
  end

  // R8
  merge_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == (|$past(res_vld)));
  // R9
  merge_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err == ($countones($past(res_vld)) > 1));
endmodule

// File: rtl/subtree_dispatch.sv
module subtree_dispatch
  import sdx_pkg::*;
#(
  parameter int unsigned P      = SDX_PIPES,
  parameter int unsigned KEY_W  = SDX_KEY_W,
  parameter int unsigned CUT_W  = SDX_CUT_W,
  parameter int unsigned T_N    = SDX_TERN_N,
  parameter int unsigned NODE_W = SDX_NODE_W,
  parameter int unsigned RES_W  = SDX_RES_W,
  localparam int unsigned PID_W = (P > 1) ? $clog2(P) : 1,
  localparam int unsigned ENT_W = PID_W + NODE_W,
  localparam int unsigned DIR_N = 1 << CUT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [KEY_W-1:0]     in_key,
  input  logic [DIR_N*ENT_W-1:0] dir_cfg,
  input  logic [T_N*KEY_W-1:0] tcam_val,
  input  logic [T_N*KEY_W-1:0] tcam_msk,
  input  logic [T_N-1:0]       tcam_en,
  input  logic [T_N*ENT_W-1:0] tcam_res,
  output logic [P-1:0]         disp_vld,
  output logic [KEY_W-1:0]     disp_key,
  output logic [NODE_W-1:0]    disp_node,
  input  logic [P-1:0]         res_vld,
  input  logic [P*RES_W-1:0]   res_data,
  output logic                 out_vld,
  output logic [RES_W-1:0]     out_data,
  output logic                 out_err
);
  logic [ENT_W-1:0] dir_tab [DIR_N];
  logic [CUT_W-1:0] cut_idx;
  logic [ENT_W-1:0] dir_ent, tern_ent, win_ent;
  logic             tern_hit;

  genvar g;
  generate
    for (g = 0; g < DIR_N; g++) begin : g_dir
      assign dir_tab[g] = dir_cfg[g*ENT_W +: ENT_W];
    end
  endgenerate

  assign cut_idx = in_key[KEY_W-1 -: CUT_W];
  assign dir_ent = dir_tab[cut_idx];

  sdx_tern_match #(.KEY_W(KEY_W), .T_N(T_N), .ENT_W(ENT_W)) u_tern (
    .key (in_key),
    .val (tcam_val),
    .msk (tcam_msk),
    .en  (tcam_en),
    .res (tcam_res),
    .hit (tern_hit),
    .ent (tern_ent)
  );

  assign win_ent = tern_hit ? tern_ent : dir_ent;

  sdx_issue #(.P(P), .KEY_W(KEY_W), .NODE_W(NODE_W)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_key   (in_key),
    .pid      (win_ent[ENT_W-1 -: PID_W]),
    .node     (win_ent[NODE_W-1:0]),
    .vld_q    (disp_vld),
    .key_q    (disp_key),
    .node_q   (disp_node)
  );

  sdx_merge #(.P(P), .RES_W(RES_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_vld  (res_vld),
    .res_data (res_data),
    .out_vld  (out_vld),
    .out_data (out_data),
    .out_err  (out_err)
  );

  // R5
  tern_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && tern_hit) |=> (disp_node == $past(tern_ent[NODE_W-1:0])));
endmodule

// File: tb/subtree_dispatch_test.sv
module subtree_dispatch_test;
  localparam int P = 8, KEY_W = 16, CUT_W = 4, T_N = 4, NODE_W = 8, RES_W = 8;
  localparam int PID_W = 3, ENT_W = PID_W + NODE_W, DIR_N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [KEY_W-1:0] in_key = '0;
  logic [DIR_N*ENT_W-1:0] dir_cfg = '0;
  logic [T_N*KEY_W-1:0] tcam_val = '0, tcam_msk = '0;
  logic [T_N-1:0] tcam_en = '0;
  logic [T_N*ENT_W-1:0] tcam_res = '0;
  logic [P-1:0] disp_vld, res_vld = '0;
  logic [KEY_W-1:0] disp_key;
  logic [NODE_W-1:0] disp_node;
  logic [P*RES_W-1:0] res_data = '0;
  logic out_vld, out_err;
  logic [RES_W-1:0] out_data;

  int checks = 0, fails = 0;
  int unsigned seed_v;

  always #4 clk = ~clk;

  subtree_dispatch uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ENT_W-1:0] model(input logic [KEY_W-1:0] k);
    for (int j = 0; j < T_N; j++) begin
      logic [KEY_W-1:0] m;
      m = tcam_msk[j*KEY_W +: KEY_W];
      if (tcam_en[j] && ((k & m) == (tcam_val[j*KEY_W +: KEY_W] & m)))
        return tcam_res[j*ENT_W +: ENT_W];
    end
    return dir_cfg[k[KEY_W-1 -: CUT_W]*ENT_W +: ENT_W];
  endfunction

  task automatic lookup(input logic [KEY_W-1:0] k, input string req);
    logic [ENT_W-1:0] e;
    e = model(k);
    in_valid = 1'b1;
    in_key = k;
    @(negedge clk);
    chk({req, "/R2"}, disp_vld, 32'(1) << e[ENT_W-1 -: PID_W]);
    chk({req, "/R3"}, disp_node, e[NODE_W-1:0]);
    chk("R7", disp_key, k);
    in_valid = 1'b0;
  endtask

  task automatic merge(input logic [P-1:0] v);
    logic [RES_W-1:0] exp_d;
    exp_d = '0;
    for (int i = P - 1; i >= 0; i--) if (v[i]) exp_d = res_data[i*RES_W +: RES_W];
    res_vld = v;
    @(negedge clk);
    chk("R8", out_vld, |v);
    if (|v) chk("R8", out_data, exp_d);
    chk("R9", out_err, $countones(v) > 1);
    res_vld = '0;
  endtask

  initial begin
    seed_v = $urandom(32'h5eed);
    for (int i = 0; i < DIR_N; i++) dir_cfg[i*ENT_W +: ENT_W] = ENT_W'($urandom);
    // entries 0 and 1 overlap; entry 3 disabled
    tcam_val[0 +: KEY_W] = 16'hA5C0; tcam_msk[0 +: KEY_W] = 16'hFFF0;
    tcam_val[KEY_W +: KEY_W] = 16'hA500; tcam_msk[KEY_W +: KEY_W] = 16'hFF00;
    tcam_val[2*KEY_W +: KEY_W] = 16'h3C3C; tcam_msk[2*KEY_W +: KEY_W] = 16'hF0F0;
    tcam_val[3*KEY_W +: KEY_W] = 16'h7777; tcam_msk[3*KEY_W +: KEY_W] = 16'hFFFF;
    tcam_en = 4'b0111;
    tcam_res = {11'h7AA, 11'h2BB, 11'h5CC, 11'h1DD};

    repeat (3) @(negedge clk);
    // R1
    chk("R1", disp_vld, 0); chk("R1", out_vld, 0); chk("R1", out_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", disp_vld, 0); chk("R1", out_vld, 0); chk("R1", out_err, 0);

    lookup(16'hA5C3, "R6");   // hits entries 0 and 1
    lookup(16'hA512, "R5");   // only entry 1, overrides direct
    lookup(16'h3A3B, "R4");   // entry 2 via masked compare
    lookup(16'h7777, "R4");   // disabled entry ignored -> direct
    lookup(16'h0001, "R3");
    @(negedge clk);
    chk("R2", disp_vld, 0);

    for (int n = 0; n < 400; n++) begin
      logic [KEY_W-1:0] k;
      int j;
      k = KEY_W'($urandom);
      if ($urandom_range(1)) begin
        j = $urandom_range(T_N - 1);
        k = tcam_val[j*KEY_W +: KEY_W] ^ (k & ~tcam_msk[j*KEY_W +: KEY_W]);
      end
      lookup(k, "R3");
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        chk("R2", disp_vld, 0);
      end
    end

    merge('0);
    merge(8'h10);
    merge(8'h81);
    merge(8'hFF);
    for (int n = 0; n < 300; n++) begin
      res_data = {$urandom, $urandom};
      if ($urandom_range(1)) merge(8'(1) << $urandom_range(P - 1));
      else merge(8'($urandom));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule